// File: doc/BRIEF.md
# Two-Bank Multiplexed Bus Latch

This block links one shared data port, A, to two bank ports, B1 and B2. Going from A to B, the A data feeds two storage latches, one per bank. Each bank port shows its own latch, so a word that appears on A can be steered to bank 1, to bank 2, or to both. Going from B to A, each bank port loads a latch of its own, and a select input decides which of those two latches appears on A. Typical uses are splitting a time-shared address/data bus into two wide banks, or interleaving two memory banks onto one narrow path.

Every latch is storage gated by its enable and clocked by the system clock. While an enable is high, the latch passes its input to the outputs in the same cycle and loads it at the clock edge. While the enable is low, the latch keeps the word from the last edge at which the enable was high. Each bidirectional pin is modelled as an input bus, an output bus and a drive flag. When a port is not driving, its output bus shows a keeper value instead of floating.

Top module: `mux_bus_latch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four latches and all three keepers to zero. After reset, with every latch enable low, each port's output is zero, whether the port is driving or not.
- R2: While `le_ab1` (or `le_ab2`) is high and B1 (or B2) is enabled, `b1_out` (or `b2_out`) equals `a_in` in the same cycle.
- R3: An A-to-B latch whose enable is low holds the `a_in` value from the last clock edge at which its enable was high. Changes on `a_in` while the enable is low do not change the stored or driven value.
- R4: With A enabled, `sel` = 1 puts the B1-path latch (loaded from `b1_in`) on `a_out`, and `sel` = 0 puts the B2-path latch (loaded from `b2_in`) on `a_out`.
- R5: The output enables `oe_a_n`, `oe_b1_n` and `oe_b2_n` are active low. Each drive flag (`a_drv`, `b1_drv`, `b2_drv`) is 1 exactly when its enable is 0.
- R6: A disabled port's output keeps the value that port drove in its last enabled cycle. It stays there for as long as the port remains disabled.
- R7: The B ports do not depend on `sel`. Each bank's output does not depend on the other bank's latch enable.
- R8: The B-to-A latches behave like the A-to-B latches. With `le_ba1` (or `le_ba2`) high, the latch is transparent to `b1_in` (or `b2_in`). With the enable low, the latch holds its value and ignores changes on that input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Data arriving on shared port A |
| a_out | output | W | Value on port A: driven data or keeper value |
| a_drv | output | 1 | Port A is driving |
| b1_in | input | W | Data arriving on bank port B1 |
| b1_out | output | W | Value on port B1: driven data or keeper value |
| b1_drv | output | 1 | Port B1 is driving |
| b2_in | input | W | Data arriving on bank port B2 |
| b2_out | output | W | Value on port B2: driven data or keeper value |
| b2_drv | output | 1 | Port B2 is driving |
| le_ab1 | input | 1 | Enable of the A-to-B1 latch |
| le_ab2 | input | 1 | Enable of the A-to-B2 latch |
| le_ba1 | input | 1 | Enable of the B1-to-A latch |
| le_ba2 | input | 1 | Enable of the B2-to-A latch |
| sel | input | 1 | B-to-A source: 1 selects the B1 path, 0 selects the B2 path |
| oe_a_n | input | 1 | Output enable of port A, active low |
| oe_b1_n | input | 1 | Output enable of port B1, active low |
| oe_b2_n | input | 1 | Output enable of port B2, active low |

## Verification
Transparent paths and drive flags are combinational, so their results are due in the same cycle as the stimulus. Stored values and keeper values take effect only from the cycle after the clock edge that loads them. The bench changes inputs on the falling edge and compares outputs 2 ns later, before the next rising edge. Its reference model updates its latch and keeper copies only at the rising edge. A sweep over every combination of enables, select and output enables, with data computed arithmetically, therefore checks each output in the cycle it is due.

// File: rtl/mux_bus_latch.sv
module mux_bus_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_drv,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_drv,
  input  logic         le_ab1,
  input  logic         le_ab2,
  input  logic         le_ba1,
  input  logic         le_ba2,
  input  logic         sel,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n
);

  logic [W-1:0] ab1_q, ab2_q, ba1_q, ba2_q;
  logic [W-1:0] ka_q, kb1_q, kb2_q;
  logic [W-1:0] ab1_v, ab2_v, ba1_v, ba2_v, a_src;

  // enable-gated storage, transparent in the enabled cycle
  assign ab1_v = le_ab1 ? a_in  : ab1_q;
  assign ab2_v = le_ab2 ? a_in  : ab2_q;
  assign ba1_v = le_ba1 ? b1_in : ba1_q;
  assign ba2_v = le_ba2 ? b2_in : ba2_q;
  assign a_src = sel ? ba1_v : ba2_v;

  assign a_drv  = ~oe_a_n;
  assign b1_drv = ~oe_b1_n;
  assign b2_drv = ~oe_b2_n;

  assign a_out  = a_drv  ? a_src : ka_q;
  assign b1_out = b1_drv ? ab1_v : kb1_q;
  assign b2_out = b2_drv ? ab2_v : kb2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab1_q <= '0;
      ab2_q <= '0;
      ba1_q <= '0;
      ba2_q <= '0;
    end else begin
      if (le_ab1) ab1_q <= a_in;
      if (le_ab2) ab2_q <= a_in;
      if (le_ba1) ba1_q <= b1_in;
      if (le_ba2) ba2_q <= b2_in;
    end
  end

  // bus-hold keepers follow the driven value
  always_ff @(posedge clk) begin
    if (rst) begin
      ka_q  <= '0;
      kb1_q <= '0;
      kb2_q <= '0;
    end else begin
      if (a_drv)  ka_q  <= a_src;
      if (b1_drv) kb1_q <= ab1_v;
      if (b2_drv) kb2_q <= ab2_v;
    end
  end

  p_thru_r2: assert property (@(posedge clk) disable iff (rst)
    (le_ab1 && !oe_b1_n) |-> b1_out == a_in);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!le_ab1 && !oe_b1_n) |=> (le_ab1 || oe_b1_n || $stable(b1_out)));

  p_sel1_r4: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && sel && le_ba1) |-> a_out == b1_in);

  p_sel0_r4: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && !sel && le_ba2) |-> a_out == b2_in);

  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!oe_b2_n ##1 oe_b2_n) |-> b2_out == $past(b2_out));

  p_float_r6: assert property (@(posedge clk) disable iff (rst)
    oe_a_n |=> (!oe_a_n || $stable(a_out)));

  p_hold_ba_r8: assert property (@(posedge clk) disable iff (rst)
    (!le_ba2 && !oe_a_n && !sel) |=> (le_ba2 || oe_a_n || sel || $stable(a_out)));

endmodule

// File: tb/test_mux_bus_latch.sv
module test_mux_bus_latch;
  localparam int W = 12;
  localparam logic [W-1:0] M = '1;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b1_drv, b2_drv;
  logic le_ab1 = 0, le_ab2 = 0, le_ba1 = 0, le_ba2 = 0, sel = 0;
  logic oe_a_n = 1, oe_b1_n = 1, oe_b2_n = 1;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  logic [W-1:0] m_ab1 = '0, m_ab2 = '0, m_ba1 = '0, m_ba2 = '0;
  logic [W-1:0] k_a = '0, k_b1 = '0, k_b2 = '0;
  logic [W-1:0] e_a, e_b1, e_b2;

  always #10 clk = ~clk;

  mux_bus_latch #(.W(W)) i_mux_bus_latch (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
    .le_ab1(le_ab1), .le_ab2(le_ab2), .le_ba1(le_ba1), .le_ba2(le_ba2),
    .sel(sel), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compute expected outputs from the reference model and compare
  task automatic compare(input string req);
    logic [W-1:0] v1, v2, u1, u2;
    v1 = le_ab1 ? a_in : m_ab1;
    v2 = le_ab2 ? a_in : m_ab2;
    u1 = le_ba1 ? b1_in : m_ba1;
    u2 = le_ba2 ? b2_in : m_ba2;
    e_b1 = !oe_b1_n ? v1 : k_b1;
    e_b2 = !oe_b2_n ? v2 : k_b2;
    e_a  = !oe_a_n ? (sel ? u1 : u2) : k_a;
    chk(req, "a_out", a_out, e_a);
    chk(req, "b1_out", b1_out, e_b1);
    chk(req, "b2_out", b2_out, e_b2);
    chk("R5", "drive flags", {{(W-3){1'b0}}, a_drv, b1_drv, b2_drv},
        {{(W-3){1'b0}}, ~oe_a_n, ~oe_b1_n, ~oe_b2_n});
  endtask

  task automatic tick;
    @(posedge clk);
    if (le_ab1) m_ab1 = a_in;
    if (le_ab2) m_ab2 = a_in;
    if (le_ba1) m_ba1 = b1_in;
    if (le_ba2) m_ba2 = b2_in;
    k_a = e_a; k_b1 = e_b1; k_b2 = e_b2;
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: reset state, disabled and then enabled ports
    chk("R1", "a_out reset", a_out, '0);
    chk("R1", "b1_out reset", b1_out, '0);
    oe_a_n = 0; oe_b1_n = 0; oe_b2_n = 0; sel = 1; a_in = 12'h5A5; b1_in = 12'h3C3; b2_in = 12'h777;
    #2;
    chk("R1", "a_out reset sel1", a_out, '0);
    chk("R1", "b1_out reset", b1_out, '0);
    chk("R1", "b2_out reset", b2_out, '0);
    compare("R1");
    tick;

    // R3: load bank1, then change a_in with enable low
    le_ab1 = 1; a_in = 12'hABC; #2; compare("R2"); tick;
    le_ab1 = 0; a_in = 12'h123; #2;
    chk("R3", "b1 held", b1_out, 12'hABC); compare("R3"); tick;
    a_in = 12'hFED; #2; chk("R3", "b1 held after change", b1_out, 12'hABC); tick;

    // R7: sel and bank2 enable leave B1 alone
    held = b1_out;
    sel = 0; le_ab2 = 1; a_in = 12'h0F0; #2;
    chk("R7", "b1 vs sel/le_ab2", b1_out, held);
    chk("R7", "b2 transparent", b2_out, 12'h0F0); compare("R7"); tick;
    le_ab2 = 0; sel = 1; #2; chk("R7", "b2 vs sel", b2_out, 12'h0F0); tick;

    // R8: B-to-A hold
    le_ba1 = 1; b1_in = 12'h456; #2; chk("R4", "a from b1", a_out, 12'h456); tick;
    le_ba1 = 0; b1_in = 12'h999; #2; chk("R8", "ba1 held", a_out, 12'h456); compare("R8"); tick;

    // R6: disable B1 and watch keeper across a_in / le changes
    held = b1_out;
    oe_b1_n = 1; le_ab1 = 1; a_in = 12'h321; #2;
    chk("R6", "b1 keeper", b1_out, held); tick;
    a_in = 12'h654; #2; chk("R6", "b1 keeper stable", b1_out, held); tick;
    le_ab1 = 0; oe_b1_n = 0; #2; chk("R3", "b1 after reenable", b1_out, 12'h654); tick;

    // sweep every control combination with arithmetic data
    for (int i = 0; i < 1024; i++) begin
      logic [7:0] c;
      c = i[7:0];
      {le_ab1, le_ab2, le_ba1, le_ba2} = c[3:0];
      sel = c[4];
      {oe_a_n, oe_b1_n, oe_b2_n} = c[7:5];
      a_in  = W'((i * 37 + 5) & M);
      b1_in = W'((i * 91 + 17) & M);
      b2_in = W'((i * 203 + 101) & M);
      #2;
      compare(c[4] ? "R4" : "R6");
      tick;
    end

    // reset again mid-run
    rst = 1; tick; rst = 0;
    m_ab1 = '0; m_ab2 = '0; m_ba1 = '0; m_ba2 = '0; k_a = '0; k_b1 = '0; k_b2 = '0;
    {le_ab1, le_ab2, le_ba1, le_ba2} = 4'b0; oe_a_n = 1; oe_b1_n = 0; oe_b2_n = 1; #2;
    chk("R1", "b1 after reset", b1_out, '0);
    chk("R1", "a keeper after reset", a_out, '0);
    chk("R1", "b2 keeper after reset", b2_out, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule